// File: doc/BRIEF.md
# Lazily Allocated Sparse Page Store

This block gives a bus master what looks like a very large byte-addressable memory, while holding only a handful of physical pages. Each request address is split into a page number (the upper bits) and an offset inside the page (the lower bits). A small, fully associative tag table records which page numbers currently own a physical slot. A page gets a slot only when it is first written with data that is not zero. Reads of pages that have never been backed return zero.

Allocation is limited by a byte budget. A new page is granted only if the bytes already in use, plus one more page, stay strictly below the budget. A write that cannot be backed is dropped without any error. A running count of the bytes in use is visible at all times. This makes the block useful as a cheap, self-filling target memory in test fabrics, where most of the address space is never touched.

Requests use a single-beat synchronous port that is always ready. Writes merge only the addressed bytes. Read data comes back one cycle after the request, together with a response strobe.

Top module: `sparse_page_store`

## Requirements
- R1: The address splits into a page number `req_addr >> log2(PAGE_BYTES)` and an offset `req_addr % PAGE_BYTES`. `PAGE_BYTES` is a power-of-two parameter. Any page number across the full address width can be backed.
- R2: A read of a page with no slot returns all-zero data and leaves `used_bytes` and the mapping unchanged.
- R3: A write to a page with no slot creates one only if all three conditions hold: (a) the write data, masked to `req_size` bytes, is nonzero; (b) `used_bytes + PAGE_BYTES < MAX_BYTES` (strict); (c) a pool slot is free. A page that would exactly fill the budget is refused.
- R4: Each allocation raises `used_bytes` by exactly `PAGE_BYTES`. `used_bytes` changes at no other time and always stays below `MAX_BYTES`.
- R5: A write to a page with no slot that fails R3 is discarded silently. Later reads of that page return zero.
- R6: `req_size` is 1 to 8 bytes, little-endian: data byte k goes to offset+k. A write to a backed page changes only those `req_size` bytes, and all other bytes keep their values. A zero write to a backed page stores zeros.
- R7: A freshly allocated page reads as zero everywhere except the bytes written by the allocating request.
- R8: A read accepted in cycle n gives `rsp_valid`=1 and `rsp_rdata` in cycle n+1. Bytes at or above `req_size` are zero. `rsp_valid` is 0 in the cycle after any cycle without a read. `req_ready` is always 1.
- R9: After reset, `used_bytes` is 0, `rsp_valid` is 0 and no page is backed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_ready | output | 1 | Always 1; the block accepts a request every cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 4 | Access size in bytes, 1 to 8 |
| req_wdata | input | 64 | Write data, little-endian, low bytes used |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 64 | Read data; unused upper bytes are zero |
| used_bytes | output | CNT_W | Bytes of backing storage allocated so far |

## Verification
The embedded checks assume every request is legal: `req_size` is between 1 and 8, and offset plus size never exceeds the page size, so no access crosses a page. The stimulus builds each offset as a random value below `PAGE_BYTES - size + 1`, which keeps every access inside its page. The addresses use a small set of page numbers, including page 0 and the highest page number, so that allocation, budget refusal and hits on existing pages all happen often. One write in four uses zero data, to exercise the rule that zero writes never allocate.

// File: rtl/sparse_page_store.sv
module sparse_page_store #(
  parameter int ADDR_W     = 32,
  parameter int PAGE_BYTES = 64,
  parameter int NSLOTS     = 8,
  parameter int MAX_BYTES  = 10 * 1024 * 1024
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  req_valid,
  output logic                                  req_ready,
  input  logic                                  req_write,
  input  logic [ADDR_W-1:0]                     req_addr,
  input  logic [3:0]                            req_size,
  input  logic [63:0]                           req_wdata,
  output logic                                  rsp_valid,
  output logic [63:0]                           rsp_rdata,
  output logic [$clog2(MAX_BYTES+1)-1:0]        used_bytes
);
  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int PN_W   = ADDR_W - OFF_W;
  localparam int SLOT_W = (NSLOTS > 1) ? $clog2(NSLOTS) : 1;
  localparam int CNT_W  = $clog2(MAX_BYTES + 1);
  localparam int MEM_N  = NSLOTS * PAGE_BYTES;
  localparam int MA_W   = (MEM_N > 1) ? $clog2(MEM_N) : 1;
  localparam logic [63:0] PAGE64 = 64'(PAGE_BYTES);
  localparam logic [63:0] MAX64  = 64'(MAX_BYTES);

  logic [7:0]        mem [MEM_N];
  logic [PN_W-1:0]   tag [NSLOTS];
  logic [NSLOTS-1:0] vld;

  logic              hit, any_free;
  logic [SLOT_W-1:0] hit_slot, free_slot;
  logic [63:0]       rd_asm;

  wire [PN_W-1:0]   pn        = req_addr[ADDR_W-1:OFF_W];
  wire [OFF_W-1:0]  off       = req_addr[OFF_W-1:0];
  wire [63:0]       size_mask = (req_size >= 4'd8) ? {64{1'b1}}
                                : ((64'd1 << {req_size, 3'b000}) - 64'd1);
  wire [63:0]       wdat      = req_wdata & size_mask;
  wire              budget_ok = (64'(used_bytes) + PAGE64) < MAX64;
  wire              wr        = req_valid & req_write;
  wire              rd        = req_valid & ~req_write;
  wire              alloc     = wr & ~hit & any_free & budget_ok & (wdat != 64'd0);
  wire [SLOT_W-1:0] wslot     = hit ? hit_slot : free_slot;

  assign req_ready = 1'b1;

  function automatic logic [MA_W-1:0] bidx(input logic [SLOT_W-1:0] s, input int o);
    return MA_W'(int'(s) * PAGE_BYTES + o);
  endfunction

  always_comb begin
    hit = 1'b0; hit_slot = '0; any_free = 1'b0; free_slot = '0;
    for (int i = NSLOTS - 1; i >= 0; i--) begin
      if (vld[i] && tag[i] == pn) begin
        hit = 1'b1; hit_slot = SLOT_W'(i);
      end
      if (!vld[i]) begin
        any_free = 1'b1; free_slot = SLOT_W'(i);
      end
    end
  end

  always_comb begin
    for (int b = 0; b < 8; b++)
      rd_asm[8*b +: 8] = (4'(b) < req_size) ? mem[bidx(hit_slot, int'(off) + b)] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (alloc)
      for (int j = 0; j < PAGE_BYTES; j++) mem[bidx(free_slot, j)] <= 8'h00;
    if (wr && (hit || alloc))
      for (int b = 0; b < 8; b++)
        if (4'(b) < req_size) mem[bidx(wslot, int'(off) + b)] <= wdat[8*b +: 8];
  end

  always_ff @(posedge clk) begin
    if (alloc) tag[free_slot] <= pn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld        <= '0;
      used_bytes <= '0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      rsp_valid <= rd;
      if (rd) rsp_rdata <= hit ? rd_asm : 64'd0;
      if (alloc) begin
        vld[free_slot] <= 1'b1;
        used_bytes     <= used_bytes + CNT_W'(PAGE_BYTES);
      end
    end
  end

  AST_LEGAL_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_size >= 4'd1 && req_size <= 4'd8 && int'(off) + int'(req_size) <= PAGE_BYTES)); // R6
  AST_UNDER_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
    64'(used_bytes) < MAX64); // R4
  AST_USED_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    used_bytes != $past(used_bytes) |-> used_bytes == $past(used_bytes) + CNT_W'(PAGE_BYTES)); // R4
  AST_ZERO_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !hit && wdat == 64'd0) |=> $stable(used_bytes)); // R3
  AST_READ_NO_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> $stable(used_bytes)); // R2
  AST_RSP_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rsp_valid); // R8
  AST_RSP_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> (rsp_rdata & ~$past(size_mask)) == 64'd0); // R8
endmodule

// File: tb/sparse_page_store_bench.sv
module sparse_page_store_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16, PB = 16, NS = 4, MAXB = 64;
  localparam int CW = $clog2(MAXB + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_ready, rsp_valid;
  logic [AW-1:0] req_addr = '0;
  logic [3:0] req_size = 4'd1;
  logic [63:0] req_wdata = '0, rsp_rdata;
  logic [CW-1:0] used_bytes;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;
  bit mapped [int];
  logic [7:0] mdl [int];
  int used_m = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sparse_page_store #(.ADDR_W(AW), .PAGE_BYTES(PB), .NSLOTS(NS), .MAX_BYTES(MAXB)) u_sparse_page_store (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .used_bytes(used_bytes));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mask_of(input int sz);
    return (sz >= 8) ? {64{1'b1}} : ((64'd1 << (8*sz)) - 64'd1);
  endfunction

  function automatic logic [63:0] exp_read(input int addr, input int sz);
    logic [63:0] r = '0;
    for (int b = 0; b < sz; b++)
      if (mapped.exists(addr / PB) && mdl.exists(addr + b)) r[8*b +: 8] = mdl[addr + b];
    return r;
  endfunction

  function automatic void model_write(input int addr, input int sz, input logic [63:0] d);
    int pn = addr / PB;
    logic [63:0] m = d & mask_of(sz);
    if (!mapped.exists(pn) && m != 0 && used_m + PB < MAXB && mapped.num() < NS) begin
      mapped[pn] = 1'b1;
      used_m += PB;
      for (int j = 0; j < PB; j++) mdl[pn*PB + j] = 8'h00;
    end
    if (mapped.exists(pn))
      for (int b = 0; b < sz; b++) mdl[addr + b] = m[8*b +: 8];
  endfunction

  task automatic do_write(input int addr, input int sz, input logic [63:0] d, input string req);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(addr); req_size = 4'(sz); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    model_write(addr, sz, d);
    check(req, 64'(used_bytes), 64'(used_m));
  endtask

  task automatic do_read(input int addr, input int sz, input string req);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(addr); req_size = 4'(sz);
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " rsp_valid"}, 64'(rsp_valid), 64'd1);
    check(req, rsp_rdata, exp_read(addr, sz));
    check({req, " used"}, 64'(used_bytes), 64'(used_m));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int pages [5] = '{0, 1, 12'h123, 12'h7FF, 12'hFFF};
    int unsigned seed_v;
    seed_v = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    check("R9 used after reset", 64'(used_bytes), 64'd0);
    check("R9 rsp_valid after reset", 64'(rsp_valid), 64'd0);
    check("R8 req_ready", 64'(req_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 no read no rsp", 64'(rsp_valid), 64'd0);
    do_read(16'h1230, 8, "R2 unmapped read zero");
    do_write(16'h1234, 4, 64'hFFFF_FFFF_0000_0000, "R3 zero masked data no alloc");
    do_read(16'h1230, 8, "R5 dropped zero write reads zero");
    do_write(16'h0003, 1, 64'hA5, "R4 first alloc adds page");
    do_read(16'h0000, 8, "R7 new page zero except written");
    do_write(16'h0008, 8, 64'h8877_6655_4433_2211, "R6 eight byte write");
    do_read(16'h000A, 4, "R6 little endian R8 upper zero");
    do_write(16'h000B, 2, 64'h1234_0000_0000_BEEF, "R6 partial merge");
    do_read(16'h0008, 8, "R6 merge keeps neighbours");
    do_write(16'hFFF8, 8, 64'h0102_0304_0506_0708, "R1 highest page alloc");
    do_read(16'hFFFC, 4, "R1 highest page read");
    do_write(16'h7FF0, 2, 64'h00FF, "R4 third alloc");
    do_write(16'h0010, 1, 64'h77, "R3 strict budget refuses page");
    do_read(16'h0010, 8, "R5 refused page reads zero");
    do_write(16'h0008, 8, 64'h0, "R6 zero write to backed page");
    do_read(16'h0008, 8, "R6 zeros stored");
    for (int i = 0; i < 400; i++) begin
      int sz = 1 + int'($urandom % 8);
      int off = int'($urandom % (PB - sz + 1));
      int addr = pages[$urandom % 5] * PB + off;
      logic [63:0] d = ($urandom % 4 == 0) ? 64'd0 : {$urandom, $urandom};
      if ($urandom % 2 == 0) do_write(addr, sz, d, "R6 random write");
      else do_read(addr, sz, "R2 R6 R8 random read");
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule